// File: doc/BRIEF.md
# Serial-Bus Register and RAM Slave

This block lets an external SPI master read and write a 64-byte on-chip store one byte at a time. The low part of the store holds the timekeeping and control registers of a real-time clock: sub-second, seconds, minutes, century/hours, day, date, month, year, control, watchdog, six alarm bytes, a few spare bytes and a square-wave setting. The rest is general-purpose RAM. The master selects the block by pulling the active-low chip select low. It sends one command byte that gives the direction and the start address. It then streams any number of data bytes, and the address moves up by one after each byte.

The serial pins are oversampled by the local clock through synchronizer stages. SDI is captured on rising SCL, and SDO changes on falling SCL. Because the edges are the same in both cases, a master may idle SCL low (mode 0) or high (mode 3). A power-fail input ends any transfer at once, clears the address pointer and locks out the bus until the master deselects. After power-fail is released, writes stay blocked for a fixed number of clock cycles, while reads are served normally.

Top module: `spi_regmem`

## Requirements
- R1: While chip select is high, the SDO output enable is low. Raising chip select ends the transfer, and the first byte after the next selection is treated as a command byte.
- R2: The command byte is sent MSB first. Bit 7 = 1 means write and bit 7 = 0 means read. Bits 5:0 give the start address.
- R3: In a write burst, each complete data byte is stored at the current address and the address then advances by one. The output enable stays low for the whole write transfer.
- R4: In a read burst, the first data bit appears on SDO after the falling SCL edge that follows the eighth command bit. Each later bit appears on a later falling edge. SDO does not change on rising edges, and the output enable is high during the data bytes.
- R5: Transfers work the same way when SCL idles high at selection (mode 3) as when it idles low (mode 0).
- R6: Command bit 6 is ignored, so addresses that differ only in bit 6 reach the same byte.
- R7: The address advances from 63 to 0 during a burst.
- R8: A write data byte cut short by chip select rising before its eighth bit leaves memory unchanged.
- R9: While power-fail is high, the transfer in progress is aborted and the address pointer is cleared. SDO output enable is low, and no SCL/SDI activity has any effect until chip select has been high with power-fail low.
- R10: For RECOVER clock cycles after power-fail falls, write data bytes are discarded while reads still return the stored data. After that window, writes land.
- R11: After reset, every byte of the store reads 0x00 and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock from the master |
| sdi_i | input | 1 | Serial data in, MSB first |
| cs_n_i | input | 1 | Active-low chip select |
| pfail_i | input | 1 | Power-fail flag, active high, synchronous to clk |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for SDO (high = drive) |

## Verification
A wrong address pointer shows up on the very next read data byte as a value from the wrong location. A pointer that fails to wrap shows up on the byte that follows location 63. A bit counter that is off by one shifts every later byte of the transfer, so the read value is rotated or the command is decoded wrongly within the same byte. A stuck lockout or protection state shows up only on the next read-back after the disturbed write, so the bench reads each write back at once. It also watches the output enable while the block is deselected, while a write is in progress and while power-fail is asserted.

// File: rtl/spi_regmem.sv
module spi_regmem #(
  parameter int AW      = 6,
  parameter int RECOVER = 2048,
  parameter int SYNC    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sdi_i,
  input  logic cs_n_i,
  input  logic pfail_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  localparam int DEPTH = 1 << AW;
  localparam int WPW   = $clog2(RECOVER + 1);
  localparam logic [AW-1:0] ONE = 1;

  logic [SYNC-1:0] scl_q, sdi_q, cs_q;
  logic scl_prev, locked;
  logic [WPW-1:0] wp_cnt;
  logic [2:0] bit_cnt;
  logic [6:0] in_sr;
  logic [7:0] out_sr;
  logic data_ph, wr_mode, rd_live;
  logic [AW-1:0] addr;
  logic [7:0] mem [DEPTH];

  wire scl_s = scl_q[SYNC-1];
  wire sdi_s = sdi_q[SYNC-1];
  wire cs_s  = cs_q[SYNC-1];
  wire sel   = !cs_s && !pfail_i && !locked;
  wire rise  = sel && scl_s && !scl_prev;
  wire fall  = sel && !scl_s && scl_prev;
  wire [7:0] byte_in = {in_sr, sdi_s};
  wire byte_end = rise && bit_cnt == 3'd7;
  wire wr_commit = byte_end && data_ph && wr_mode && wp_cnt == '0;

  assign sdo_o    = out_sr[7];
  assign sdo_oe_o = sel && rd_live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= '0; sdi_q <= '0; cs_q <= '1; scl_prev <= 1'b0;
    end else begin
      scl_q <= {scl_q[SYNC-2:0], scl_i};
      sdi_q <= {sdi_q[SYNC-2:0], sdi_i};
      cs_q  <= {cs_q[SYNC-2:0], cs_n_i};
      scl_prev <= scl_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      wp_cnt <= '0;
    end else if (pfail_i) begin
      locked <= 1'b1;
      wp_cnt <= WPW'(RECOVER);
    end else begin
      if (cs_s) locked <= 1'b0;
      if (wp_cnt != '0) wp_cnt <= wp_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || pfail_i) begin
      bit_cnt <= '0; in_sr <= '0; out_sr <= '0;
      data_ph <= 1'b0; wr_mode <= 1'b0; rd_live <= 1'b0; addr <= '0;
    end else if (!sel) begin
      bit_cnt <= '0; data_ph <= 1'b0; wr_mode <= 1'b0; rd_live <= 1'b0;
    end else begin
      if (rise) begin
        in_sr   <= byte_in[6:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          if (!data_ph) begin
            data_ph <= 1'b1;
            wr_mode <= byte_in[7];
            addr    <= byte_in[AW-1:0];
          end else if (wr_mode) begin
            addr <= addr + ONE;
          end
        end
      end
      if (fall && data_ph && !wr_mode) begin
        if (bit_cnt == 3'd0) begin
          out_sr  <= mem[addr];
          addr    <= addr + ONE;
          rd_live <= 1'b1;
        end else begin
          out_sr <= {out_sr[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_commit) begin
      mem[addr] <= byte_in;
    end
  end

  p_oe_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |-> !sdo_oe_o);
  p_wr_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |-> !sdo_oe_o);
  p_sdo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> $stable(sdo_o));
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && data_ph && wr_mode && addr == '1) |=> addr == '0);
  p_pf_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pfail_i |=> (addr == '0 && bit_cnt == 3'd0 && !sdo_oe_o));
  p_wp_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pfail_i) |-> wp_cnt != '0);
endmodule

// File: tb/test_spi_regmem.sv
module test_spi_regmem;
  localparam int H = 8;
  localparam int RECOVER = 2048;
  logic clk = 0, rst_n = 0, scl = 0, sdi = 0, cs_n = 1, pfail = 0;
  logic sdo, oe;
  int checks = 0, failures = 0;

  spi_regmem i_spi_regmem (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sdi_i(sdi),
    .cs_n_i(cs_n), .pfail_i(pfail), .sdo_o(sdo), .sdo_oe_o(oe));

  always #4 clk = ~clk;

  task automatic wc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sel(input logic m3);
    scl = m3; wc(4); cs_n = 0; wc(H);
  endtask

  task automatic desel(input logic m3);
    if (!m3) begin scl = 0; wc(H); end
    cs_n = 1; wc(H);
  endtask

  task automatic xb(input logic [7:0] tx, input int nbits, output logic [7:0] rx, output logic oe_all);
    oe_all = 1; rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      scl = 0; sdi = tx[i]; wc(H);
      rx[i] = sdo; if (!oe) oe_all = 0;
      scl = 1; wc(H);
    end
  endtask

  task automatic wr1(input logic m3, input logic [7:0] a, input logic [7:0] d, output logic oe_seen);
    logic [7:0] rx; logic o1, o2;
    sel(m3); xb(8'h80 | a, 8, rx, o1); xb(d, 8, rx, o2); desel(m3);
    oe_seen = o1 | o2;
  endtask

  task automatic rd1(input logic m3, input logic [7:0] a, output logic [7:0] q, output logic oe_ok);
    logic [7:0] rx; logic o;
    sel(m3); xb(a & 8'h7F, 8, rx, o); xb(8'h00, 8, q, oe_ok); desel(m3);
  endtask

  task automatic t_reset;
    logic [7:0] q; logic o;
    check(oe === 1'b0, "R11 oe after reset", oe, 0);
    rd1(0, 8'h3A, q, o);
    check(q === 8'h00, "R11 cleared byte", q, 0);
  endtask

  task automatic t_burst_mode0;
    logic [7:0] rx, q; logic o, ow;
    logic [7:0] d [4] = '{8'hA5, 8'h3C, 8'hF0, 8'h01};
    ow = 0;
    sel(0); xb(8'h85, 8, rx, o);
    for (int k = 0; k < 4; k++) begin xb(d[k], 8, rx, o); ow = ow | o; end
    desel(0);
    check(ow === 1'b0, "R3 oe low in write", ow, 0);
    sel(0); xb(8'h05, 8, rx, o);
    for (int k = 0; k < 4; k++) begin
      xb(8'h00, 8, q, o);
      check(q === d[k], "R2 R3 R4 burst readback", q, d[k]);
      check(o === 1'b1, "R4 oe during read", o, 1);
    end
    desel(0);
    check(oe === 1'b0, "R1 oe after deselect", oe, 0);
  endtask

  task automatic t_mode3;
    logic [7:0] q; logic o;
    wr1(1, 8'h20, 8'h6D, o);
    rd1(1, 8'h20, q, o);
    check(q === 8'h6D, "R5 mode3 readback", q, 8'h6D);
    rd1(0, 8'h20, q, o);
    check(q === 8'h6D, "R5 mode3 write mode0 read", q, 8'h6D);
  endtask

  task automatic t_bit6;
    logic [7:0] q; logic o;
    wr1(0, 8'h4A, 8'hC3, o);
    rd1(0, 8'h0A, q, o);
    check(q === 8'hC3, "R6 alias bit6", q, 8'hC3);
    rd1(0, 8'h4A, q, o);
    check(q === 8'hC3, "R6 read with bit6", q, 8'hC3);
  endtask

  task automatic t_wrap;
    logic [7:0] rx, q; logic o;
    sel(0); xb(8'hBF, 8, rx, o); xb(8'h9E, 8, rx, o); xb(8'h2B, 8, rx, o); desel(0);
    rd1(0, 8'h3F, q, o);
    check(q === 8'h9E, "R7 byte at 63", q, 8'h9E);
    rd1(0, 8'h00, q, o);
    check(q === 8'h2B, "R7 wrapped to 0", q, 8'h2B);
    sel(0); xb(8'h3F, 8, rx, o); xb(0, 8, q, o); xb(0, 8, rx, o); desel(0);
    check(rx === 8'h2B, "R7 read wrap", rx, 8'h2B);
  endtask

  task automatic t_partial;
    logic [7:0] rx, q; logic o;
    sel(0); xb(8'hB0, 8, rx, o); xb(8'h11, 8, rx, o); xb(8'hFF, 5, rx, o); desel(0);
    rd1(0, 8'h30, q, o);
    check(q === 8'h11, "R8 full byte kept", q, 8'h11);
    rd1(0, 8'h31, q, o);
    check(q === 8'h00, "R8 partial dropped", q, 0);
  endtask

  task automatic t_deselect;
    logic [7:0] rx, q; logic o;
    sel(0); xb(8'h90, 8, rx, o); desel(0);
    sel(0); xb(8'h91, 8, rx, o); xb(8'h5A, 8, rx, o); desel(0);
    rd1(0, 8'h11, q, o);
    check(q === 8'h5A, "R1 new command after reselect", q, 8'h5A);
    rd1(0, 8'h10, q, o);
    check(q === 8'h00, "R1 first byte not data", q, 0);
  endtask

  task automatic t_pfail;
    logic [7:0] rx, q; logic o;
    wr1(0, 8'h15, 8'hAA, o);
    sel(0); xb(8'h15, 8, rx, o); xb(0, 3, rx, o);
    pfail = 1; wc(2);
    check(oe === 1'b0, "R9 oe low in power-fail", oe, 0);
    wc(18); pfail = 0;
    xb(8'h95, 8, rx, o); xb(8'h55, 8, rx, o); desel(0);
    rd1(0, 8'h15, q, o);
    check(q === 8'hAA, "R9 input locked out", q, 8'hAA);
    wr1(0, 8'h16, 8'h77, o);
    rd1(0, 8'h16, q, o);
    check(q === 8'h00, "R10 write in window dropped", q, 0);
    wc(RECOVER + 50);
    wr1(0, 8'h16, 8'h77, o);
    rd1(0, 8'h16, q, o);
    check(q === 8'h77, "R10 write after window", q, 8'h77);
  endtask

  initial begin
    wc(5); rst_n = 1; wc(4);
    t_reset;
    t_burst_mode0;
    t_mode3;
    t_bit6;
    t_wrap;
    t_partial;
    t_deselect;
    t_pfail;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule